// File: doc/BRIEF.md
# Floating-Point Divide Special-Case Resolver

This block sits in front of a floating-point divider. Both operands arrive already unpacked into a class code, a sign, an exponent and a mantissa. In one registered stage the block settles every quotient that needs no mantissa division. It propagates a NaN operand, generates the default NaN for invalid forms, returns the dividend for the cases where it already is the answer, and produces a signed zero or a signed infinity. For these cases it supplies the complete result fields and the exception flags. Only when both operands are ordinary numbers does it raise `do_div`, which hands the work to the mantissa datapath. The quotient sign is offered on its own output on every cycle.

The class code is three bits wide: 0 zero, 1 normal number, 2 infinity, 3 quiet NaN, 4 signalling NaN. Codes 5 to 7 must not be applied. The operand choice is deliberately asymmetric. A signalling NaN wins over a quiet one. Results taken from the dividend keep the dividend's own sign, not the product of the two signs.

Top module: `fdiv_special_resolve`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, every output is 0 (result class code 0).
- R2: Every output reflects the operand inputs sampled at the previous rising clock edge; the outputs do not change between edges.
- R3: If either class is 3 or 4, the result copies class, sign, exponent and mantissa from the operand of higher NaN rank (4 above 3 above non-NaN). On equal rank the divisor is taken. No flag is raised and `do_div` is 0.
- R4: Infinity/infinity and zero/zero give the default NaN: class 3, sign 0, exponent all ones, mantissa all ones. `flag_nv` is 1.
- R5: A dividend of class 0 or 2, divided by a non-NaN divisor of a different class, returns the dividend's class, sign, exponent and mantissa unchanged, with no flag.
- R6: A number divided by infinity gives class 0 with sign a XOR b, exponent 0, mantissa 0 and no flag.
- R7: A number divided by zero gives class 2 with sign a XOR b, exponent 0, mantissa 0, and `flag_dz` set to 1.
- R8: Only number/number sets `do_div`. In that case the result class is 1, the sign is a XOR b, and the exponent and mantissa are 0. `quo_sign` always equals a XOR b of the sampled inputs.
- R9: `flag_nv` and `flag_dz` are never both 1, and both are 0 whenever `do_div` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_class | input | 3 | Dividend class code |
| a_sign | input | 1 | Dividend sign |
| a_exp | input | EXP_W | Dividend exponent |
| a_mant | input | MANT_W | Dividend mantissa |
| b_class | input | 3 | Divisor class code |
| b_sign | input | 1 | Divisor sign |
| b_exp | input | EXP_W | Divisor exponent |
| b_mant | input | MANT_W | Divisor mantissa |
| res_class | output | 3 | Early result class code |
| res_sign | output | 1 | Early result sign |
| res_exp | output | EXP_W | Early result exponent |
| res_mant | output | MANT_W | Early result mantissa |
| flag_nv | output | 1 | Invalid-operation flag |
| flag_dz | output | 1 | Divide-by-zero flag |
| do_div | output | 1 | Quotient needs the mantissa divider |
| quo_sign | output | 1 | XOR of operand signs |

## Verification
The only state is the single output register. A wrong case decision, a wrong NaN choice or a wrong sign source therefore shows at the ports on the cycle right after the operands were applied. The bench walks all 25 class pairs several times with random signs, exponents and mantissas, so any swapped operand or mis-ordered priority shows as a field mismatch within one cycle. A stale register or a missing reset shows in the reset check and in the check between clock edges.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [2:0] {
        CL_ZERO = 3'd0,
        CL_NUM  = 3'd1,
        CL_INF  = 3'd2,
        CL_QNAN = 3'd3,
        CL_SNAN = 3'd4
    } fclass_e;

    typedef enum logic [2:0] {
        SC_NAN_FWD,
        SC_INVALID,
        SC_KEEP_A,
        SC_MAKE_ZERO,
        SC_MAKE_INF,
        SC_DIVIDE
    } scase_e;

    function automatic logic [1:0] nan_rank(input logic [2:0] c);
        case (c)
            CL_SNAN: nan_rank = 2'd2;
            CL_QNAN: nan_rank = 2'd1;
            default: nan_rank = 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/fdiv_nan_pick.sv
module fdiv_nan_pick
    import fdiv_pkg::*;
(
    input  logic [2:0] a_class,
    input  logic [2:0] b_class,
    output logic       any_nan,
    output logic       take_b
);
    logic [1:0] rank_a;
    logic [1:0] rank_b;

    always_comb begin
        rank_a  = nan_rank(a_class);
        rank_b  = nan_rank(b_class);
        any_nan = (rank_a != 2'd0) || (rank_b != 2'd0);
        // the divisor wins ties so that a double quiet NaN returns b
        take_b  = !(rank_a > rank_b);
    end
endmodule

// File: rtl/fdiv_case_decide.sv
module fdiv_case_decide
    import fdiv_pkg::*;
(
    input  logic [2:0] a_class,
    input  logic [2:0] b_class,
    input  logic       any_nan,
    output scase_e     sel
);
    always_comb begin
        sel = SC_DIVIDE;
        if (any_nan) begin
            sel = SC_NAN_FWD;
        end else if (a_class == CL_INF || a_class == CL_ZERO) begin
            sel = (a_class == b_class) ? SC_INVALID : SC_KEEP_A;
        end else if (b_class == CL_INF) begin
            sel = SC_MAKE_ZERO;
        end else if (b_class == CL_ZERO) begin
            sel = SC_MAKE_INF;
        end else begin
            sel = SC_DIVIDE;
        end
    end
endmodule

// File: rtl/fdiv_special_resolve.sv
module fdiv_special_resolve
    import fdiv_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int MANT_W = 53
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        a_class,
    input  logic              a_sign,
    input  logic [EXP_W-1:0]  a_exp,
    input  logic [MANT_W-1:0] a_mant,
    input  logic [2:0]        b_class,
    input  logic              b_sign,
    input  logic [EXP_W-1:0]  b_exp,
    input  logic [MANT_W-1:0] b_mant,
    output logic [2:0]        res_class,
    output logic              res_sign,
    output logic [EXP_W-1:0]  res_exp,
    output logic [MANT_W-1:0] res_mant,
    output logic              flag_nv,
    output logic              flag_dz,
    output logic              do_div,
    output logic              quo_sign
);
    localparam logic [EXP_W-1:0]  DEF_EXP  = {EXP_W{1'b1}};
    localparam logic [MANT_W-1:0] DEF_MANT = {MANT_W{1'b1}};

    typedef struct packed {
        logic [2:0]        cls;
        logic              sign;
        logic [EXP_W-1:0]  exp;
        logic [MANT_W-1:0] mant;
        logic              nv;
        logic              dz;
        logic              div;
        logic              qsign;
    } out_t;

    logic   any_nan;
    logic   take_b;
    scase_e sel;
    out_t   out_d;
    out_t   out_q;
    logic   sx;

    fdiv_nan_pick u_pick (
        .a_class (a_class),
        .b_class (b_class),
        .any_nan (any_nan),
        .take_b  (take_b)
    );

    fdiv_case_decide u_decide (
        .a_class (a_class),
        .b_class (b_class),
        .any_nan (any_nan),
        .sel     (sel)
    );

    always_comb begin
        sx          = a_sign ^ b_sign;
        out_d       = '0;
        out_d.qsign = sx;
        case (sel)
            SC_NAN_FWD: begin
                out_d.cls  = take_b ? b_class : a_class;
                out_d.sign = take_b ? b_sign  : a_sign;
                out_d.exp  = take_b ? b_exp   : a_exp;
                out_d.mant = take_b ? b_mant  : a_mant;
            end
            SC_INVALID: begin
                out_d.cls  = CL_QNAN;
                out_d.sign = 1'b0;
                out_d.exp  = DEF_EXP;
                out_d.mant = DEF_MANT;
                out_d.nv   = 1'b1;
            end
            SC_KEEP_A: begin
                out_d.cls  = a_class;
                out_d.sign = a_sign;
                out_d.exp  = a_exp;
                out_d.mant = a_mant;
            end
            SC_MAKE_ZERO: begin
                out_d.cls  = CL_ZERO;
                out_d.sign = sx;
            end
            SC_MAKE_INF: begin
                out_d.cls  = CL_INF;
                out_d.sign = sx;
                out_d.dz   = 1'b1;
            end
            default: begin
                out_d.cls  = CL_NUM;
                out_d.sign = sx;
                out_d.div  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign res_class = out_q.cls;
    assign res_sign  = out_q.sign;
    assign res_exp   = out_q.exp;
    assign res_mant  = out_q.mant;
    assign flag_nv   = out_q.nv;
    assign flag_dz   = out_q.dz;
    assign do_div    = out_q.div;
    assign quo_sign  = out_q.qsign;
endmodule

// File: rtl/fdiv_special_resolve_chk.sv
module fdiv_special_resolve_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] a_class,
    input logic       a_sign,
    input logic [2:0] b_class,
    input logic       b_sign,
    input logic [2:0] res_class,
    input logic       flag_nv,
    input logic       flag_dz,
    input logic       do_div,
    input logic       quo_sign
);
    logic live_q;

    always_ff @(posedge clk) begin
        if (!rst_n) live_q <= 1'b0;
        else        live_q <= 1'b1;
    end

    p_flag_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(flag_nv && flag_dz));

    p_div_noflag_r9: assert property (@(posedge clk) disable iff (!rst_n)
        do_div |-> (!flag_nv && !flag_dz));

    p_div_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        do_div |-> ($past(a_class) == 3'd1 && $past(b_class) == 3'd1));

    p_dz_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flag_dz |-> ($past(a_class) == 3'd1 && $past(b_class) == 3'd0));

    p_nv_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_nv |-> ($past(a_class) == $past(b_class)
                     && ($past(a_class) == 3'd0 || $past(a_class) == 3'd2)));

    p_qsign_r8: assert property (@(posedge clk) disable iff (!rst_n)
        live_q |-> (quo_sign == ($past(a_sign) ^ $past(b_sign))));

    p_nan_out_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && ($past(a_class) >= 3'd3 || $past(b_class) >= 3'd3))
            |-> (res_class == 3'd3 || res_class == 3'd4));
endmodule

bind fdiv_special_resolve fdiv_special_resolve_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .a_class   (a_class),
    .a_sign    (a_sign),
    .b_class   (b_class),
    .b_sign    (b_sign),
    .res_class (res_class),
    .flag_nv   (flag_nv),
    .flag_dz   (flag_dz),
    .do_div    (do_div),
    .quo_sign  (quo_sign)
);

// File: tb/test_fdiv_special_resolve.sv
module test_fdiv_special_resolve;
    localparam int EW = 11;
    localparam int MW = 53;
    localparam int OW = 3 + 1 + EW + MW + 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [2:0]    a_class, b_class;
    logic          a_sign, b_sign;
    logic [EW-1:0] a_exp, b_exp;
    logic [MW-1:0] a_mant, b_mant;
    logic [2:0]    res_class;
    logic          res_sign;
    logic [EW-1:0] res_exp;
    logic [MW-1:0] res_mant;
    logic          flag_nv, flag_dz, do_div, quo_sign;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fdiv_special_resolve #(.EXP_W(EW), .MANT_W(MW)) i_fdiv_special_resolve (
        .clk(clk), .rst_n(rst_n),
        .a_class(a_class), .a_sign(a_sign), .a_exp(a_exp), .a_mant(a_mant),
        .b_class(b_class), .b_sign(b_sign), .b_exp(b_exp), .b_mant(b_mant),
        .res_class(res_class), .res_sign(res_sign), .res_exp(res_exp),
        .res_mant(res_mant), .flag_nv(flag_nv), .flag_dz(flag_dz),
        .do_div(do_div), .quo_sign(quo_sign)
    );

    logic [OW-1:0] expv;
    string         tag;

    function automatic int rank(input logic [2:0] c);
        if (c == 3'd4) return 2;
        if (c == 3'd3) return 1;
        return 0;
    endfunction

    // behavioural reference: {class, sign, exp, mant, nv, dz, div, qsign}
    task automatic model();
        logic x;
        x = a_sign ^ b_sign;
        if (rank(a_class) + rank(b_class) > 0) begin
            tag = "R3";
            if (rank(a_class) > rank(b_class)) expv = {a_class, a_sign, a_exp, a_mant, 3'b000, x};
            else                               expv = {b_class, b_sign, b_exp, b_mant, 3'b000, x};
        end else if ((a_class == 3'd2 || a_class == 3'd0) && a_class == b_class) begin
            tag = "R4";
            expv = {3'd3, 1'b0, {EW{1'b1}}, {MW{1'b1}}, 3'b100, x};
        end else if (a_class == 3'd2 || a_class == 3'd0) begin
            tag = "R5";
            expv = {a_class, a_sign, a_exp, a_mant, 3'b000, x};
        end else if (b_class == 3'd2) begin
            tag = "R6";
            expv = {3'd0, x, {EW{1'b0}}, {MW{1'b0}}, 3'b000, x};
        end else if (b_class == 3'd0) begin
            tag = "R7";
            expv = {3'd2, x, {EW{1'b0}}, {MW{1'b0}}, 3'b010, x};
        end else begin
            tag = "R8";
            expv = {3'd1, x, {EW{1'b0}}, {MW{1'b0}}, 3'b001, x};
        end
    endtask

    function automatic logic [OW-1:0] actual();
        return {res_class, res_sign, res_exp, res_mant, flag_nv, flag_dz, do_div, quo_sign};
    endfunction

    task automatic check(input string t, input logic [OW-1:0] act, input logic [OW-1:0] want);
        n_chk++;
        if (act !== want) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", t, act, want);
        end
    endtask

    task automatic drive(input logic [2:0] ca, input logic [2:0] cb);
        a_class = ca; b_class = cb;
        a_sign = 1'($urandom); b_sign = 1'($urandom);
        a_exp = EW'($urandom); b_exp = EW'($urandom);
        a_mant = {$urandom, $urandom}; b_mant = {$urandom, $urandom};
        model();
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        rst_n = 1'b0;
        drive(3'd1, 3'd0);
        repeat (3) @(negedge clk);
        check("R1", actual(), '0);           // R1: outputs cleared in reset
        rst_n = 1'b1;
        #1;
        check("R1", actual(), '0);           // R1: still zero before first edge
        @(negedge clk);
        check("R7", actual(), expv);

        for (int r = 0; r < 4; r++) begin
            for (int ia = 0; ia < 5; ia++) begin
                for (int ib = 0; ib < 5; ib++) begin
                    drive(3'(ia), 3'(ib));
                    @(negedge clk);
                    check(tag, actual(), expv);
                    // R9: flags exclusive and silent on divide
                    check("R9", {1'b0, (flag_nv & flag_dz) | (do_div & (flag_nv | flag_dz))}, 2'b00);
                end
            end
        end

        // R3 ties: both quiet / both signalling take the divisor
        drive(3'd3, 3'd3); @(negedge clk); check("R3", actual(), expv);
        check("R3", {res_sign, res_mant}, {b_sign, b_mant});
        drive(3'd4, 3'd4); @(negedge clk); check("R3", actual(), expv);
        check("R3", {res_sign, res_exp}, {b_sign, b_exp});

        // R2: outputs hold until the edge
        drive(3'd1, 3'd1); @(negedge clk);
        drive(3'd1, 3'd0);
        #2;
        check("R2", {do_div, flag_dz}, 2'b10);
        @(negedge clk);
        check("R2", {do_div, flag_dz}, 2'b01);

        finish_run();
    end
endmodule